// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a small bank of ownership flags shared by two ports, called left and right. Software on each side uses a flag to claim a shared resource before it touches that resource, and then gives the flag back. A port reaches the bank by raising its semaphore select. A short index picks one flag. A write either asks for the token or gives it back. A read reports whether the reading port holds the token.

The bank enforces mutual exclusion. A request for a flag that the other side holds is queued. It is granted on the same clock edge that the holder gives the flag back. When both ports ask for a free flag on the same edge, the left port wins and the right request stays queued. All state updates on the rising clock edge. The read data is combinational from the registered ownership state.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free and no request is queued. A read of any index by either port returns 1, including reads of a flag that had a queued request before reset.
- R2: No flag is ever held by both ports at once.
- R3: A write with select high, write enable high and token bit 0 is a request. A request for a free flag grants it to the writing port at that clock edge.
- R4: A request for a flag held by the other port does not change the owner. The request stays queued.
- R5: A write with token bit 1 is a release. When the holder releases a flag that the other port has queued, the flag passes to the other port at the same edge.
- R6: When both ports request the same free flag in the same cycle, the left port is granted. The right request stays queued.
- R7: A release by a port that does not hold the flag leaves the current owner unchanged.
- R8: The index input picks one of NUM_SEM flags. An operation on one index does not affect any other flag.
- R9: A write or read with select low has no effect on any flag.
- R10: A read needs select high, output enable high and write enable low. In every other case rdata is 1.
- R11: During a valid read, rdata is 0 when the reading port holds the indexed flag and 1 when it does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 1 | Left semaphore select |
| l_we_i | input | 1 | Left write enable |
| l_oe_i | input | 1 | Left output enable |
| l_idx_i | input | IDX_W | Left flag index |
| l_tok_i | input | 1 | Left write data: 0 request, 1 release |
| l_rdata_o | output | 1 | Left read: 0 when left holds the flag |
| r_sel_i | input | 1 | Right semaphore select |
| r_we_i | input | 1 | Right write enable |
| r_oe_i | input | 1 | Right output enable |
| r_idx_i | input | IDX_W | Right flag index |
| r_tok_i | input | 1 | Right write data: 0 request, 1 release |
| r_rdata_o | output | 1 | Right read: 0 when right holds the flag |

## Verification
The assertions check on every cycle that:
- no flag has two owners;
- an owner keeps its flag until it releases it;
- a queued request is granted at the holder's release;
- the left port wins a tie for a free flag;
- idle selects leave the state unchanged;
- a non-read returns 1.

Only the bench scenarios can show the following:
- the bit sense of the read data and the decoding of each index;
- that queued requests are cleared by reset;
- that a release by a non-holder leaves the owner unchanged, seen from the owner's side of the ports.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned NUM_SEM_DEF = 8;

  typedef struct packed {
    logic own_l;
    logic own_r;
    logic pend_l;
    logic pend_r;
  } sem_state_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int unsigned NUM_SEM = 8,
  localparam int unsigned IDX_W = $clog2(NUM_SEM)
) (
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             tok_i,
  output logic [NUM_SEM-1:0] req_o,
  output logic [NUM_SEM-1:0] rel_o
);
  logic wr;
  assign wr = sel_i & we_i;

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
    logic hit;
    assign hit      = wr && (idx_i == IDX_W'(i));
    assign req_o[i] = hit & ~tok_i;
    assign rel_o[i] = hit &  tok_i;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       l_req_i,
  input  logic       l_rel_i,
  input  logic       r_req_i,
  input  logic       r_rel_i,
  output sem_state_t st_o
);
  sem_state_t st_q, st_d;
  logic hl, hr, pl, pr, free, gl, gr;

  always_comb begin
    hl   = st_q.own_l & ~l_rel_i;
    hr   = st_q.own_r & ~r_rel_i;
    // a holder's own request is moot; a release withdraws a queued request
    pl   = (st_q.pend_l | l_req_i) & ~st_q.own_l & ~l_rel_i;
    pr   = (st_q.pend_r | r_req_i) & ~st_q.own_r & ~r_rel_i;
    free = ~hl & ~hr;
    gl   = free & pl;
    gr   = free & pr & ~pl;
    st_d.own_l  = hl | gl;
    st_d.own_r  = hr | gr;
    st_d.pend_l = pl & ~gl;
    st_d.pend_r = pr & ~gr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
  parameter int unsigned NUM_SEM = 8,
  localparam int unsigned IDX_W = $clog2(NUM_SEM)
) (
  input  logic               sel_i,
  input  logic               we_i,
  input  logic               oe_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [NUM_SEM-1:0] own_i,
  output logic               rdata_o
);
  always_comb begin
    rdata_o = 1'b1;
    if (sel_i && oe_i && !we_i) rdata_o = ~own_i[idx_i];
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int unsigned NUM_SEM = NUM_SEM_DEF,
  localparam int unsigned IDX_W = $clog2(NUM_SEM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l_sel_i,
  input  logic             l_we_i,
  input  logic             l_oe_i,
  input  logic [IDX_W-1:0] l_idx_i,
  input  logic             l_tok_i,
  output logic             l_rdata_o,
  input  logic             r_sel_i,
  input  logic             r_we_i,
  input  logic             r_oe_i,
  input  logic [IDX_W-1:0] r_idx_i,
  input  logic             r_tok_i,
  output logic             r_rdata_o
);
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] own_l, own_r, pend_l, pend_r;

  sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_l (
    .sel_i(l_sel_i), .we_i(l_we_i), .idx_i(l_idx_i), .tok_i(l_tok_i),
    .req_o(l_req), .rel_o(l_rel)
  );

  sem_port_decode #(.NUM_SEM(NUM_SEM)) u_dec_r (
    .sel_i(r_sel_i), .we_i(r_we_i), .idx_i(r_idx_i), .tok_i(r_tok_i),
    .req_o(r_req), .rel_o(r_rel)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sem_state_t st;
    sem_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .l_req_i(l_req[i]), .l_rel_i(l_rel[i]),
      .r_req_i(r_req[i]), .r_rel_i(r_rel[i]),
      .st_o(st)
    );
    assign own_l[i]  = st.own_l;
    assign own_r[i]  = st.own_r;
    assign pend_l[i] = st.pend_l;
    assign pend_r[i] = st.pend_r;
  end

  sem_read_mux #(.NUM_SEM(NUM_SEM)) u_rd_l (
    .sel_i(l_sel_i), .we_i(l_we_i), .oe_i(l_oe_i), .idx_i(l_idx_i),
    .own_i(own_l), .rdata_o(l_rdata_o)
  );

  sem_read_mux #(.NUM_SEM(NUM_SEM)) u_rd_r (
    .sel_i(r_sel_i), .we_i(r_we_i), .oe_i(r_oe_i), .idx_i(r_idx_i),
    .own_i(own_r), .rdata_o(r_rdata_o)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int unsigned NUM_SEM = 8,
  localparam int unsigned IDX_W = $clog2(NUM_SEM)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_sel_i,
  input logic               l_we_i,
  input logic               l_oe_i,
  input logic [IDX_W-1:0]   l_idx_i,
  input logic               l_tok_i,
  input logic               l_rdata_o,
  input logic               r_sel_i,
  input logic               r_we_i,
  input logic               r_oe_i,
  input logic [IDX_W-1:0]   r_idx_i,
  input logic               r_tok_i,
  input logic               r_rdata_o,
  input logic [NUM_SEM-1:0] own_l,
  input logic [NUM_SEM-1:0] own_r,
  input logic [NUM_SEM-1:0] pend_l,
  input logic [NUM_SEM-1:0] pend_r
);
  for (genvar i = 0; i < NUM_SEM; i++) begin : g_chk
    assert_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({own_l[i], own_r[i]}));

    assert_hold_l_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_l[i] && !(l_sel_i && l_we_i && l_tok_i && l_idx_i == IDX_W'(i))
      |=> own_l[i]);

    assert_hold_r_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_r[i] && !(r_sel_i && r_we_i && r_tok_i && r_idx_i == IDX_W'(i))
      |=> own_r[i]);

    assert_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      own_r[i] && pend_l[i] && r_sel_i && r_we_i && r_tok_i
      && r_idx_i == IDX_W'(i) && !(l_sel_i && l_we_i && l_idx_i == IDX_W'(i))
      |=> own_l[i]);
  end

  assert_tie_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_sel_i && l_we_i && !l_tok_i && r_sel_i && r_we_i && !r_tok_i
    && l_idx_i == r_idx_i && !own_l[l_idx_i] && !own_r[l_idx_i]
    |=> own_l[$past(l_idx_i)] && pend_r[$past(l_idx_i)]);

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_sel_i && !r_sel_i
    |=> $stable(own_l) && $stable(own_r) && $stable(pend_l) && $stable(pend_r));

  assert_noread_l_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_sel_i && l_oe_i && !l_we_i) |-> l_rdata_o);

  assert_noread_r_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(r_sel_i && r_oe_i && !r_we_i) |-> r_rdata_o);
endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_sel_i(l_sel_i), .l_we_i(l_we_i), .l_oe_i(l_oe_i), .l_idx_i(l_idx_i),
  .l_tok_i(l_tok_i), .l_rdata_o(l_rdata_o),
  .r_sel_i(r_sel_i), .r_we_i(r_we_i), .r_oe_i(r_oe_i), .r_idx_i(r_idx_i),
  .r_tok_i(r_tok_i), .r_rdata_o(r_rdata_o),
  .own_l(own_l), .own_r(own_r), .pend_l(pend_l), .pend_r(pend_r)
);

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
  localparam int unsigned NUM_SEM = 8;
  localparam int unsigned NV = 20;

  // op encoding {sel, we, oe, idx[2:0], tok}
  function automatic logic [6:0] op_rd(input logic [2:0] a);
    return {3'b101, a, 1'b1};
  endfunction
  function automatic logic [6:0] op_req(input logic [2:0] a);
    return {3'b110, a, 1'b0};
  endfunction
  function automatic logic [6:0] op_rel(input logic [2:0] a);
    return {3'b110, a, 1'b1};
  endfunction
  function automatic logic [6:0] op_nosel(input logic [2:0] a);
    return {3'b010, a, 1'b0};
  endfunction
  function automatic logic [6:0] op_nooe(input logic [2:0] a);
    return {3'b100, a, 1'b1};
  endfunction
  localparam logic [6:0] IDLE = 7'd0;

  // vector {l_op, r_op, exp_l, exp_r, req_no}
  localparam logic [19:0] VEC [NV] = '{
    {op_rd(0),    op_rd(0),    2'b11, 4'd1},   // R1
    {op_req(2),   IDLE,        2'b11, 4'd3},   // R3
    {op_rd(2),    op_rd(2),    2'b01, 4'd11},  // R11
    {op_rd(2),    op_req(2),   2'b01, 4'd4},   // R4
    {op_rd(2),    op_rd(2),    2'b01, 4'd4},   // R4
    {op_rel(2),   op_rd(2),    2'b11, 4'd5},   // R5
    {op_rd(2),    op_rd(2),    2'b10, 4'd5},   // R5
    {op_req(5),   op_req(5),   2'b11, 4'd6},   // R6
    {op_rd(5),    op_rd(5),    2'b01, 4'd6},   // R6
    {op_rel(2),   IDLE,        2'b11, 4'd7},   // R7
    {op_rd(2),    op_rd(2),    2'b10, 4'd7},   // R7
    {op_rel(5),   op_rd(5),    2'b11, 4'd5},   // R5
    {op_rd(5),    op_rd(5),    2'b10, 4'd5},   // R5
    {op_nosel(7), op_nosel(7), 2'b11, 4'd9},   // R9
    {op_rd(7),    op_rd(7),    2'b11, 4'd9},   // R9
    {op_req(0),   IDLE,        2'b11, 4'd3},   // R3
    {op_nooe(0),  op_rd(0),    2'b11, 4'd10},  // R10
    {op_rd(0),    op_rd(1),    2'b01, 4'd8},   // R8
    {op_rd(3),    op_rd(5),    2'b10, 4'd8},   // R8
    {op_rd(0),    op_req(0),   2'b01, 4'd4}    // R4: right queued on 0
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic l_sel, l_we, l_oe, l_tok, r_sel, r_we, r_oe, r_tok;
  logic [2:0] l_idx, r_idx;
  logic l_rdata, r_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sem_bank #(.NUM_SEM(NUM_SEM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_sel_i(l_sel), .l_we_i(l_we), .l_oe_i(l_oe), .l_idx_i(l_idx),
    .l_tok_i(l_tok), .l_rdata_o(l_rdata),
    .r_sel_i(r_sel), .r_we_i(r_we), .r_oe_i(r_oe), .r_idx_i(r_idx),
    .r_tok_i(r_tok), .r_rdata_o(r_rdata)
  );

  task automatic drive(input logic [6:0] lo, input logic [6:0] ro);
    {l_sel, l_we, l_oe, l_idx, l_tok} = lo;
    {r_sel, r_we, r_oe, r_idx, r_tok} = ro;
  endtask

  task automatic check(input logic [1:0] exp, input int rq, input string tag);
    checks++;
    if ({l_rdata, r_rdata} !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got l=%b r=%b expected l=%b r=%b",
               rq, tag, l_rdata, r_rdata, exp[1], exp[0]);
    end
  endtask

  initial begin
    drive(IDLE, IDLE);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      drive(VEC[v][19:13], VEC[v][12:6]);
      #1 check(VEC[v][5:4], int'(VEC[v][3:0]), $sformatf("vector %0d", v));
    end
    // R1: async reset clears owners and the queued right request on 0
    @(negedge clk);
    drive(IDLE, IDLE);
    rst_ni = 1'b0;
    #1 check(2'b11, 1, "during reset");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NUM_SEM; i++) begin
      @(negedge clk);
      drive(op_rd(3'(i)), op_rd(3'(i)));
      #1 check(2'b11, 1, $sformatf("post-reset idx %0d", i));
    end
    // R3 corner: last index, right side grant
    @(negedge clk);
    drive(IDLE, op_req(7));
    @(negedge clk);
    drive(op_rd(7), op_rd(7));
    #1 check(2'b10, 3, "right grant idx 7");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule